// File: doc/BRIEF.md
# Serial Flash Status and Write-Protection Controller

This block holds the 8-bit status byte of a serial NOR flash device and decides which decoded instructions the device takes. An upstream decoder presents one-cycle instruction strobes: read status, write enable, write disable, status write (with its data byte), page program and three erase sizes. The block accepts or drops each strobe under a single policy that combines three rules. A busy lockout blocks all instructions except read status. A write-enable latch gates the modifying instructions and clears itself when they finish. A lock on status writes depends on a stored protect bit and an external write-protect pin.

A down-counter models the internal operation time, with a separate cycle count for each kind of modifying instruction. The status byte is combinational from the stored state, so it is valid on every cycle. A consumer polling it during an operation sees the busy flag fall on the cycle the operation ends. The protection fields are also brought out on their own so that a downstream address checker can use them.

Top module: `sf_status_ctrl`

## Requirements
- R1: After the asynchronous reset `rst_ni` goes low, `status_o` reads 0x00, and `bp_o`, `tb_o` and `srp_o` are all 0.
- R2: While status bit 0 (busy) is 1, `accept_o` equals `rdsr_i` and every other strobe is dropped with no change of state.
- R3: When not busy, write enable sets status bit 1 (write-enable latch) at the next clock edge, and write disable clears it.
- R4: A page program, sector erase, block erase, chip erase or status write is accepted only when bit 1 is 1 and bit 0 is 0. Otherwise `accept_o` is 0 and no state changes.
- R5: An accepted modifying instruction sets bit 0 from the next cycle for exactly its parameter count (PROG_CYC, SE_CYC, BE_CYC, CE_CYC, WRSR_CYC). Bit 1 clears on the same edge that bit 0 falls.
- R6: An unlocked status write copies data bits 7, 5 and 4:2 into status bits 7 (status-register protect), 5 (top/bottom select) and 4:2 (block-protect field) on the edge where bit 0 falls. `srp_o`, `tb_o` and `bp_o` mirror these bits.
- R7: A status write accepted while bit 7 is 1 and `wp_ni` is 0 is locked. It still runs its busy period and clears bit 1, but it leaves bits 7 and 5:2 unchanged.
- R8: Status bit 6 always reads 0, even after a status write with data bit 6 set.
- R9: When several strobes are high in a non-busy cycle, only the highest-priority one is considered: chip erase, then block erase, sector erase, page program, status write, write disable, write enable, read status.
- R10: Read status alone is always accepted. `status_o` reflects the current state on every cycle, including each cycle of a busy period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rdsr_i | input | 1 | Read-status strobe |
| wren_i | input | 1 | Write-enable strobe |
| wrdi_i | input | 1 | Write-disable strobe |
| wrsr_i | input | 1 | Status-write strobe |
| wrsr_data_i | input | 8 | Data byte for a status write |
| prog_i | input | 1 | Page-program strobe |
| se_i | input | 1 | Sector-erase strobe |
| be_i | input | 1 | Block-erase strobe |
| ce_i | input | 1 | Chip-erase strobe |
| wp_ni | input | 1 | Write-protect pin level; low asserts protection |
| status_o | output | 8 | Status byte |
| accept_o | output | 1 | The strobe in this cycle is taken |
| bp_o | output | 3 | Block-protect field |
| tb_o | output | 1 | Top/bottom select |
| srp_o | output | 1 | Status-register protect bit |

## Verification
The bench targets the edge where busy falls. A design that cleared the latch one cycle late, or applied the status data at acceptance, would show a wrong byte for one cycle. Strobes issued during busy, and modifying strobes issued with the latch clear, check that a leaky lockout neither starts a second operation nor changes the latch. Locked status writes with the pin low, followed by the same write with the pin high, catch a lock that ignores the pin or that also suppresses the busy period. Stacked strobes and a long pseudo-random stream catch a wrong priority order or a miscounted duration.

// File: rtl/sf_status_pkg.sv
package sf_status_pkg;

  localparam int STATUS_W = 8;
  localparam int NUM_CMD  = 8;

  localparam int BIT_BUSY = 0;
  localparam int BIT_WEL  = 1;
  localparam int BP_LSB   = 2;
  localparam int BP_W     = 3;
  localparam int BIT_TB   = 5;
  localparam int BIT_SRP  = 7;

  // Value order matches strobe priority: higher value wins.
  typedef enum logic [3:0] {
    OP_NONE = 4'd0,
    OP_RDSR = 4'd1,
    OP_WREN = 4'd2,
    OP_WRDI = 4'd3,
    OP_WRSR = 4'd4,
    OP_PP   = 4'd5,
    OP_SE   = 4'd6,
    OP_BE   = 4'd7,
    OP_CE   = 4'd8
  } op_e;

  typedef struct packed {
    logic            srp;
    logic            tb;
    logic [BP_W-1:0] bp;
  } prot_t;

  function automatic logic is_modify(op_e op);
    return op inside {OP_WRSR, OP_PP, OP_SE, OP_BE, OP_CE};
  endfunction

  function automatic int max5(int a, int b, int c, int d, int e);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    if (e > m) m = e;
    return m;
  endfunction

endpackage

// File: rtl/sf_cmd_arbiter.sv
module sf_cmd_arbiter
  import sf_status_pkg::*;
(
  input  logic [NUM_CMD-1:0] req_i,
  input  logic               busy_i,
  input  logic               wel_i,
  output op_e                op_o,
  output logic               accept_o,
  output logic               start_o
);

  op_e pick;

  always_comb begin
    pick = OP_NONE;
    for (int i = 0; i < NUM_CMD; i++) begin
      if (req_i[i]) pick = op_e'(4'(i + 1));
    end
  end

  always_comb begin
    op_o     = OP_NONE;
    accept_o = 1'b0;
    if (busy_i) begin
      // only read status passes the lockout
      op_o     = req_i[0] ? OP_RDSR : OP_NONE;
      accept_o = req_i[0];
    end else begin
      op_o = pick;
      unique case (pick)
        OP_NONE:                   accept_o = 1'b0;
        OP_RDSR, OP_WREN, OP_WRDI: accept_o = 1'b1;
        default:                   accept_o = wel_i;
      endcase
    end
  end

  assign start_o = accept_o && is_modify(op_o);

endmodule

// File: rtl/sf_busy_timer.sv
module sf_busy_timer
  import sf_status_pkg::*;
#(
  parameter int PROG_CYC = 5,
  parameter int SE_CYC   = 7,
  parameter int BE_CYC   = 9,
  parameter int CE_CYC   = 11,
  parameter int WRSR_CYC = 3,
  parameter int CNT_W    = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  op_e  op_i,
  output logic busy_o,
  output logic done_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] dur;

  always_comb begin
    unique case (op_i)
      OP_PP:   dur = CNT_W'(PROG_CYC);
      OP_SE:   dur = CNT_W'(SE_CYC);
      OP_BE:   dur = CNT_W'(BE_CYC);
      OP_CE:   dur = CNT_W'(CE_CYC);
      OP_WRSR: dur = CNT_W'(WRSR_CYC);
      default: dur = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (start_i)         cnt_q <= dur;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = cnt_q != '0;
  assign done_o = cnt_q == CNT_W'(1);

endmodule

// File: rtl/sf_status_regs.sv
module sf_status_regs
  import sf_status_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  op_e                 op_i,
  input  logic                accept_i,
  input  logic                done_i,
  input  logic [STATUS_W-1:0] wr_data_i,
  input  logic                wp_ni,
  output logic                wel_o,
  output prot_t               prot_o
);

  prot_t prot_q, pend_q;
  logic  wel_q, pend_v_q, pend_lock_q;
  logic  lock;

  assign lock = prot_q.srp && !wp_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wel_q       <= 1'b0;
      prot_q      <= '0;
      pend_q      <= '0;
      pend_v_q    <= 1'b0;
      pend_lock_q <= 1'b0;
    end else if (done_i) begin
      wel_q    <= 1'b0;
      pend_v_q <= 1'b0;
      if (pend_v_q && !pend_lock_q) prot_q <= pend_q;
    end else if (accept_i) begin
      unique case (op_i)
        OP_WREN: wel_q <= 1'b1;
        OP_WRDI: wel_q <= 1'b0;
        OP_WRSR: begin
          pend_v_q    <= 1'b1;
          pend_lock_q <= lock;
          pend_q      <= '{srp: wr_data_i[BIT_SRP],
                           tb:  wr_data_i[BIT_TB],
                           bp:  wr_data_i[BP_LSB +: BP_W]};
        end
        default: ;
      endcase
    end
  end

  assign wel_o  = wel_q;
  assign prot_o = prot_q;

endmodule

// File: rtl/sf_status_ctrl.sv
module sf_status_ctrl
  import sf_status_pkg::*;
#(
  parameter int PROG_CYC = 5,
  parameter int SE_CYC   = 7,
  parameter int BE_CYC   = 9,
  parameter int CE_CYC   = 11,
  parameter int WRSR_CYC = 3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                rdsr_i,
  input  logic                wren_i,
  input  logic                wrdi_i,
  input  logic                wrsr_i,
  input  logic [STATUS_W-1:0] wrsr_data_i,
  input  logic                prog_i,
  input  logic                se_i,
  input  logic                be_i,
  input  logic                ce_i,
  input  logic                wp_ni,
  output logic [STATUS_W-1:0] status_o,
  output logic                accept_o,
  output logic [BP_W-1:0]     bp_o,
  output logic                tb_o,
  output logic                srp_o
);

  localparam int MAX_CYC = max5(PROG_CYC, SE_CYC, BE_CYC, CE_CYC, WRSR_CYC);
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  logic [NUM_CMD-1:0] req;
  op_e   op;
  logic  start, busy, done, wel;
  prot_t prot;

  assign req = {ce_i, be_i, se_i, prog_i, wrsr_i, wrdi_i, wren_i, rdsr_i};

  sf_cmd_arbiter u_arb (
    .req_i    (req),
    .busy_i   (busy),
    .wel_i    (wel),
    .op_o     (op),
    .accept_o (accept_o),
    .start_o  (start)
  );

  sf_busy_timer #(
    .PROG_CYC (PROG_CYC),
    .SE_CYC   (SE_CYC),
    .BE_CYC   (BE_CYC),
    .CE_CYC   (CE_CYC),
    .WRSR_CYC (WRSR_CYC),
    .CNT_W    (CNT_W)
  ) u_tmr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .op_i    (op),
    .busy_o  (busy),
    .done_o  (done)
  );

  sf_status_regs u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .op_i      (op),
    .accept_i  (accept_o),
    .done_i    (done),
    .wr_data_i (wrsr_data_i),
    .wp_ni     (wp_ni),
    .wel_o     (wel),
    .prot_o    (prot)
  );

  always_comb begin
    status_o                     = '0;
    status_o[BIT_BUSY]           = busy;
    status_o[BIT_WEL]            = wel;
    status_o[BP_LSB +: BP_W]     = prot.bp;
    status_o[BIT_TB]             = prot.tb;
    status_o[BIT_SRP]            = prot.srp;
  end

  assign bp_o  = prot.bp;
  assign tb_o  = prot.tb;
  assign srp_o = prot.srp;

endmodule

// File: rtl/sf_status_chk.sv
module sf_status_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       rdsr_i,
  input logic       wrsr_i,
  input logic       prog_i,
  input logic       se_i,
  input logic       be_i,
  input logic       ce_i,
  input logic       wp_ni,
  input logic [7:0] status_o,
  input logic       accept_o
);

  logic any_mod;
  logic locked_q;

  assign any_mod = wrsr_i | prog_i | se_i | be_i | ce_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)
      locked_q <= 1'b0;
    else if (accept_o && !status_o[0] && wrsr_i && !(prog_i | se_i | be_i | ce_i)
             && status_o[7] && !wp_ni)
      locked_q <= 1'b1;
    else if (!status_o[0])
      locked_q <= 1'b0;
  end

  AST_BUSY_LOCKOUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[0] |-> (accept_o == rdsr_i)); // R2

  AST_NO_WEL_NO_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!status_o[0] && !status_o[1] && any_mod) |-> !accept_o); // R4

  AST_NO_WEL_NO_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!status_o[0] && !status_o[1] && any_mod) |=> !status_o[0]); // R4

  AST_START_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!status_o[0] && status_o[1] && any_mod) |=> status_o[0]); // R5

  AST_WEL_CLR_AT_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(status_o[0]) |-> !status_o[1]); // R5

  AST_LOCK_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_q |-> $stable(status_o[7:2])); // R7

endmodule

bind sf_status_ctrl sf_status_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .rdsr_i   (rdsr_i),
  .wrsr_i   (wrsr_i),
  .prog_i   (prog_i),
  .se_i     (se_i),
  .be_i     (be_i),
  .ce_i     (ce_i),
  .wp_ni    (wp_ni),
  .status_o (status_o),
  .accept_o (accept_o)
);

// File: tb/sf_status_ctrl_test.sv
module sf_status_ctrl_test;

  localparam int P_CYC = 5;
  localparam int S_CYC = 7;
  localparam int B_CYC = 9;
  localparam int C_CYC = 11;
  localparam int W_CYC = 3;

  localparam bit [7:0] RD = 8'h01, WE = 8'h02, WD = 8'h04, WS = 8'h08;
  localparam bit [7:0] PP = 8'h10, SE = 8'h20, BE = 8'h40, CE = 8'h80;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_ni;
  logic       rdsr_i, wren_i, wrdi_i, wrsr_i, prog_i, se_i, be_i, ce_i, wp_ni;
  logic [7:0] wrsr_data_i;
  logic [7:0] status_o;
  logic       accept_o;
  logic [2:0] bp_o;
  logic       tb_o, srp_o;

  sf_status_ctrl #(
    .PROG_CYC (P_CYC), .SE_CYC (S_CYC), .BE_CYC (B_CYC),
    .CE_CYC (C_CYC), .WRSR_CYC (W_CYC)
  ) uut (
    .clk_i (clk), .rst_ni (rst_ni),
    .rdsr_i (rdsr_i), .wren_i (wren_i), .wrdi_i (wrdi_i), .wrsr_i (wrsr_i),
    .wrsr_data_i (wrsr_data_i), .prog_i (prog_i), .se_i (se_i), .be_i (be_i),
    .ce_i (ce_i), .wp_ni (wp_ni), .status_o (status_o), .accept_o (accept_o),
    .bp_o (bp_o), .tb_o (tb_o), .srp_o (srp_o)
  );

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;
  bit cur_wp = 1'b1;

  // behavioural reference state
  int       m_cnt = 0;
  bit       m_wel = 0, m_srp = 0, m_tb = 0;
  bit [2:0] m_bp = '0;
  bit       m_pv = 0, m_pl = 0;
  bit [7:0] m_pd = '0;

  function automatic bit [7:0] exp_status();
    return {m_srp, 1'b0, m_tb, m_bp, m_wel, m_cnt > 0};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc(input bit [7:0] req, input bit [7:0] d, input string tag);
    int op;
    bit acc;
    {ce_i, be_i, se_i, prog_i, wrsr_i, wrdi_i, wren_i, rdsr_i} = req;
    wrsr_data_i = d;
    wp_ni = cur_wp;
    #1;
    op = -1;
    for (int i = 0; i < 8; i++) if (req[i]) op = i;
    if (m_cnt > 0)    acc = req[0];
    else if (op < 0)  acc = 1'b0;
    else if (op >= 3) acc = m_wel;
    else              acc = 1'b1;
    chk({tag, " status"}, 32'(status_o), 32'(exp_status()));
    chk({tag, " accept"}, 32'(accept_o), 32'(acc));
    chk({tag, " prot"}, 32'({srp_o, tb_o, bp_o}), 32'({m_srp, m_tb, m_bp}));
    @(posedge clk);
    if (m_cnt > 0) begin
      m_cnt--;
      if (m_cnt == 0) begin
        m_wel = 1'b0;
        if (m_pv && !m_pl) begin
          m_srp = m_pd[7]; m_tb = m_pd[5]; m_bp = m_pd[4:2];
        end
        m_pv = 1'b0;
      end
    end else if (acc) begin
      case (op)
        1: m_wel = 1'b1;
        2: m_wel = 1'b0;
        3: begin m_cnt = W_CYC; m_pv = 1'b1; m_pd = d; m_pl = m_srp && !cur_wp; end
        4: m_cnt = P_CYC;
        5: m_cnt = S_CYC;
        6: m_cnt = B_CYC;
        7: m_cnt = C_CYC;
        default: ;
      endcase
    end
    @(negedge clk);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(8'h00, 8'h00, tag);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    #(200000 * 8);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    bit [15:0] lfsr;
    rst_ni = 1'b0;
    {ce_i, be_i, se_i, prog_i, wrsr_i, wrdi_i, wren_i, rdsr_i} = '0;
    wrsr_data_i = '0;
    wp_ni = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 status", 32'(status_o), 32'h0);
    chk("R1 prot", 32'({srp_o, tb_o, bp_o}), 32'h0);
    rst_ni = 1'b1;
    @(negedge clk);

    // R4: modifying strobes with latch clear are dropped
    cyc(PP, 0, "R4"); cyc(CE, 0, "R4"); cyc(WS, 8'hFC, "R4");
    idle(2, "R4");
    // R3: latch set and clear
    cyc(WE, 0, "R3"); cyc(RD, 0, "R3"); cyc(WD, 0, "R3"); cyc(RD, 0, "R3");
    // R5 + R2: program, then strobes during busy
    cyc(WE, 0, "R5"); cyc(PP, 0, "R5");
    cyc(WE, 0, "R2"); cyc(CE, 0, "R2"); cyc(RD | WD, 0, "R2"); cyc(RD, 0, "R10");
    idle(3, "R5");
    chk("R5 wel cleared", 32'(status_o[1]), 32'h0);
    // each erase size
    cyc(WE, 0, "R5"); cyc(SE, 0, "R5"); idle(S_CYC + 1, "R5");
    cyc(WE, 0, "R5"); cyc(BE, 0, "R5"); idle(B_CYC + 1, "R5");
    cyc(WE, 0, "R5"); cyc(CE, 0, "R5");
    for (int i = 0; i < C_CYC + 1; i++) cyc(RD, 0, "R10");
    // R6/R8: unlocked status write with bit 6 set
    cyc(WE, 0, "R6"); cyc(WS, 8'hFF, "R6"); idle(W_CYC + 1, "R6");
    chk("R8 reserved", 32'(status_o[6]), 32'h0);
    chk("R6 fields", 32'({srp_o, tb_o, bp_o}), 32'h1F);
    // R7: locked with pin low
    cur_wp = 1'b0;
    cyc(WE, 0, "R7"); cyc(WS, 8'h00, "R7"); idle(W_CYC + 1, "R7");
    chk("R7 fields kept", 32'({srp_o, tb_o, bp_o}), 32'h1F);
    chk("R7 wel cleared", 32'(status_o[1]), 32'h0);
    // pin high releases the lock
    cur_wp = 1'b1;
    cyc(WE, 0, "R6"); cyc(WS, 8'h28, "R6"); idle(W_CYC + 1, "R6");
    chk("R6 fields", 32'({srp_o, tb_o, bp_o}), 32'h0A);
    // R9: priority
    cyc(CE | WE, 0, "R9"); idle(1, "R9");
    cyc(WE | RD, 0, "R9"); idle(1, "R9");
    cyc(CE | WD | PP, 0, "R9"); idle(C_CYC + 1, "R9");
    cyc(WE, 0, "R9"); cyc(WD | WE | RD, 0, "R9"); idle(1, "R9");
    // R10: pseudo-random stream
    lfsr = 16'hACE1;
    for (int n = 0; n < 1500; n++) begin
      bit [7:0] rq;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      rq = '0;
      if (lfsr[3:2] != 2'b00) rq[lfsr[6:4]] = 1'b1;
      if (lfsr[8:7] == 2'b11) rq[1] = 1'b1;
      if (lfsr[15:12] == 4'hF) cur_wp = ~cur_wp;
      cyc(rq, lfsr[15:8], "R10");
    end

    finished = 1'b1;
    summary();
    $finish;
  end

endmodule